// File: doc/BRIEF.md
# Clock Status Change Interrupt Unit

This block keeps watch over two clock health indicators and tells software when either one changes. The first indicator is the lock signal of a phase-locked loop, which arrives from another clock domain and is resynchronised inside the block. The second is an oscillator-qualified status that the block derives itself. An enabled oscillator counts as qualified only while the synchronised lock is high and the part is not in full stop. With the spike filter enabled, lock must also have stayed high for a programmable number of cycles.

Each indicator has a sticky change flag that is set on a transition in either direction. Software clears a flag by writing 1 to its bit through a one-cycle write strobe. Each flag is masked by its own interrupt enable, and the two masked requests are ORed into one registered interrupt line. All state uses a synchronous active-high reset.

Top module: `clk_status_irq`

## Requirements
- R1: During and after reset, with no stimulus, `osc_qual`, `lock_flag`, `osc_flag` and `irq` are all 0.
- R2: `lock_in` passes through two synchroniser flops. Any change of `lock_in`, rising or falling, that is held sets `lock_flag` at the third rising edge after the change.
- R3: A cycle with `wr_en`=1 clears `lock_flag` at that edge if `wr_data[0]`=1, and clears `osc_flag` if `wr_data[1]`=1. A flag whose `wr_data` bit is 0 keeps its value.
- R4: When a change event and a write-1-to-clear of the same flag meet at one edge, the flag ends up set.
- R5: While `osc_en` is 0, `osc_qual` is 0 from the next edge onward.
- R6: With `osc_en`=1, `full_stop`=0 and `filt_en`=0, `osc_qual` goes to 1 at the third rising edge after `lock_in` rises.
- R7: With `filt_en`=1, `osc_qual` goes to 1 only once the synchronised lock, `osc_en`=1 and `full_stop`=0 have held together for QUAL_CYCLES consecutive edges. Any break in these conditions restarts the count from zero.
- R8: A loss of synchronised lock clears `osc_qual` at the next edge. So does `full_stop`=1.
- R9: `osc_flag` is set at the edge after any transition of `osc_qual`, in either direction.
- R10: `irq` is registered. At each edge it takes (`lock_flag` AND `lock_ie`) OR (`osc_flag` AND `osc_ie`) as they stood before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| lock_in | input | 1 | Asynchronous PLL lock indicator |
| osc_en | input | 1 | Oscillator enable |
| filt_en | input | 1 | Qualification filter enable |
| full_stop | input | 1 | Full-stop mode indicator |
| lock_ie | input | 1 | Lock-change interrupt enable |
| osc_ie | input | 1 | Oscillator-change interrupt enable |
| wr_en | input | 1 | Flag register write strobe |
| wr_data | input | 2 | Write-1-to-clear data: bit 0 lock flag, bit 1 oscillator flag |
| osc_qual | output | 1 | Oscillator-qualified status |
| lock_flag | output | 1 | Sticky lock-change flag |
| osc_flag | output | 1 | Sticky oscillator-change flag |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench issues a clear strobe on every cycle while lock toggles. This lands a clear exactly on a change event, where a design that gave clear the priority would drop a change. In filter mode, lock is pulled low for a short time part-way through the qualification window. A counter that only paused instead of restarting would qualify too early. Full stop and oscillator disable are applied while lock stays high, and a design that tied the qualified status to lock alone would keep it at 1. The interrupt enables are toggled while flags are set, and a design that ignored a mask or left out the output register would show up as an `irq` one cycle off or present when masked.

// File: rtl/csi_pkg.sv
package csi_pkg;
  localparam int NUM_SRC  = 2;
  localparam int SRC_LOCK = 0;  // wr_data bit for the lock flag
  localparam int SRC_OSC  = 1;  // wr_data bit for the oscillator flag
endpackage

// File: rtl/csi_sync.sv
module csi_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/csi_qual.sv
module csi_qual #(
  parameter int QUAL_CYCLES = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic lock_s,
  input  logic osc_en,
  input  logic filt_en,
  input  logic full_stop,
  output logic qual
);
  localparam int CW = $clog2(QUAL_CYCLES + 1);
  localparam logic [CW-1:0] CMAX = CW'(QUAL_CYCLES);
  localparam logic [CW-1:0] CTHR = CW'(QUAL_CYCLES - 1);

  logic          ok;
  logic [CW-1:0] cnt;

  assign ok = osc_en & ~full_stop & lock_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      qual <= 1'b0;
    end else if (!ok) begin
      cnt  <= '0;
      qual <= 1'b0;
    end else begin
      if (cnt != CMAX) cnt <= cnt + 1'b1;
      qual <= ~filt_en | (cnt >= CTHR);
    end
  end
endmodule

// File: rtl/csi_flag.sv
module csi_flag (
  input  logic clk,
  input  logic rst,
  input  logic level,
  input  logic clr,
  output logic flag
);
  logic level_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      level_d <= 1'b0;
      flag    <= 1'b0;
    end else begin
      level_d <= level;
      // a change event outranks a clear at the same edge
      flag    <= (level ^ level_d) | (flag & ~clr);
    end
  end
endmodule

// File: rtl/clk_status_irq.sv
module clk_status_irq #(
  parameter int SYNC_STAGES = 2,
  parameter int QUAL_CYCLES = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       lock_in,
  input  logic       osc_en,
  input  logic       filt_en,
  input  logic       full_stop,
  input  logic       lock_ie,
  input  logic       osc_ie,
  input  logic       wr_en,
  input  logic [1:0] wr_data,
  output logic       osc_qual,
  output logic       lock_flag,
  output logic       osc_flag,
  output logic       irq
);
  import csi_pkg::*;

  logic               lock_s;
  logic [NUM_SRC-1:0] level, clr, flags, ie;

  csi_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(lock_in), .q(lock_s)
  );

  csi_qual #(.QUAL_CYCLES(QUAL_CYCLES)) u_qual (
    .clk(clk), .rst(rst), .lock_s(lock_s), .osc_en(osc_en),
    .filt_en(filt_en), .full_stop(full_stop), .qual(osc_qual)
  );

  assign level[SRC_LOCK] = lock_s;
  assign level[SRC_OSC]  = osc_qual;
  assign ie[SRC_LOCK]    = lock_ie;
  assign ie[SRC_OSC]     = osc_ie;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_flag
    assign clr[i] = wr_en & wr_data[i];
    csi_flag u_flag (
      .clk(clk), .rst(rst), .level(level[i]), .clr(clr[i]), .flag(flags[i])
    );
  end

  assign lock_flag = flags[SRC_LOCK];
  assign osc_flag  = flags[SRC_OSC];

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |(flags & ie);
  end
endmodule

// File: rtl/csi_chk.sv
module csi_chk (
  input logic       clk,
  input logic       rst,
  input logic       osc_en,
  input logic       full_stop,
  input logic       lock_ie,
  input logic       osc_ie,
  input logic       wr_en,
  input logic [1:0] wr_data,
  input logic       osc_qual,
  input logic       lock_flag,
  input logic       osc_flag,
  input logic       irq
);
  // R5: oscillator off forces the qualified status low
  a_r5_osc_off: assert property (@(posedge clk) disable iff (rst)
    !osc_en |=> !osc_qual);

  // R8: full stop forces the qualified status low
  a_r8_stop_drop: assert property (@(posedge clk) disable iff (rst)
    full_stop |=> !osc_qual);

  // R3: a set lock flag stays set unless cleared
  a_r3_lock_sticky: assert property (@(posedge clk) disable iff (rst)
    (lock_flag && !(wr_en && wr_data[0])) |=> lock_flag);

  // R3: a set oscillator flag stays set unless cleared
  a_r3_osc_sticky: assert property (@(posedge clk) disable iff (rst)
    (osc_flag && !(wr_en && wr_data[1])) |=> osc_flag);

  // R9: any qualified-status transition sets the oscillator flag
  a_r9_osc_change: assert property (@(posedge clk) disable iff (rst)
    (osc_qual != $past(osc_qual)) |=> osc_flag);

  // R10: registered, masked OR of the two flags
  a_r10_irq: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq == $past((lock_flag && lock_ie) || (osc_flag && osc_ie))));
endmodule

bind clk_status_irq csi_chk u_chk (
  .clk(clk), .rst(rst), .osc_en(osc_en), .full_stop(full_stop),
  .lock_ie(lock_ie), .osc_ie(osc_ie), .wr_en(wr_en), .wr_data(wr_data),
  .osc_qual(osc_qual), .lock_flag(lock_flag), .osc_flag(osc_flag), .irq(irq)
);

// File: tb/sim_clk_status_irq.sv
module sim_clk_status_irq;
  localparam int CLK_PERIOD = 10;
  localparam int QC = 8;

  logic clk = 0, rst = 1;
  logic lock_in = 0, osc_en = 0, filt_en = 0, full_stop = 0;
  logic lock_ie = 0, osc_ie = 0, wr_en = 0;
  logic [1:0] wr_data = 2'b00;
  logic osc_qual, lock_flag, osc_flag, irq;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  string phase = "R1 reset";

  // reference model state
  int m_s1, m_s2, m_ld, m_cnt, m_q, m_qd, m_lf, m_of, m_irq;

  clk_status_irq #(.SYNC_STAGES(2), .QUAL_CYCLES(QC)) u0 (
    .clk(clk), .rst(rst), .lock_in(lock_in), .osc_en(osc_en),
    .filt_en(filt_en), .full_stop(full_stop), .lock_ie(lock_ie),
    .osc_ie(osc_ie), .wr_en(wr_en), .wr_data(wr_data),
    .osc_qual(osc_qual), .lock_flag(lock_flag), .osc_flag(osc_flag), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    int ok, lev, oev, n_s1, n_s2, n_ld, n_cnt, n_q, n_qd, n_lf, n_of, n_irq;
    cyc++;
    if (rst) begin
      m_s1 = 0; m_s2 = 0; m_ld = 0; m_cnt = 0; m_q = 0; m_qd = 0;
      m_lf = 0; m_of = 0; m_irq = 0;
    end else begin
      lev  = (m_s2 != m_ld);
      ok   = osc_en && !full_stop && m_s2;
      n_cnt = ok ? ((m_cnt + 1 > QC) ? QC : m_cnt + 1) : 0;
      n_q  = ok && (!filt_en || m_cnt >= QC - 1);
      oev  = (m_q != m_qd);
      n_lf = lev || (m_lf && !(wr_en && wr_data[0]));
      n_of = oev || (m_of && !(wr_en && wr_data[1]));
      n_irq = (m_lf && lock_ie) || (m_of && osc_ie);
      n_s1 = lock_in; n_s2 = m_s1; n_ld = m_s2; n_qd = m_q;
      m_s1 = n_s1; m_s2 = n_s2; m_ld = n_ld; m_cnt = n_cnt; m_q = n_q;
      m_qd = n_qd; m_lf = n_lf; m_of = n_of; m_irq = n_irq;
    end
  end

  task automatic cmp(string sig, logic act, int exp);
    n_cmp++;
    if (act !== exp[0]) begin
      n_bad++;
      $display("FAIL %s %s cycle %0d: actual %b expected %0d", phase, sig, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cyc > 0) begin
      cmp("osc_qual (R5 R6 R7 R8)", osc_qual, m_q);
      cmp("lock_flag (R2 R3 R4)", lock_flag, m_lf);
      cmp("osc_flag (R9 R3 R4)", osc_flag, m_of);
      cmp("irq (R10)", irq, m_irq);
    end
  end

  task automatic step(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
    end
  endtask

  task automatic wr(logic [1:0] d);
    @(negedge clk); #1; wr_en = 1; wr_data = d;
    @(negedge clk); #1; wr_en = 0; wr_data = 2'b00;
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 100000);
    n_bad++;
    $display("FAIL watchdog expired: actual hung expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    step(4);
    phase = "R1 reset"; rst = 0; step(3);

    phase = "R6 bypass qualify"; osc_en = 1; lock_ie = 1; osc_ie = 1;
    lock_in = 1; step(8);

    phase = "R3 clear zero-write"; wr(2'b00); step(2);
    phase = "R3 clear lock"; wr(2'b01); step(2);
    phase = "R3 clear osc"; wr(2'b10); step(3);

    phase = "R8 lock loss"; lock_in = 0; step(6);
    wr(2'b11); step(2);

    phase = "R4 set beats clear";
    wr_en = 1; wr_data = 2'b11;
    lock_in = 1; step(4); lock_in = 0; step(4); lock_in = 1; step(4);
    wr_en = 0; wr_data = 2'b00; step(3);

    phase = "R5 osc disabled"; osc_en = 0; step(4);
    phase = "R5 osc held off with lock toggling"; lock_in = 0; step(4);
    lock_in = 1; step(6);
    wr(2'b11);

    phase = "R7 filter window"; filt_en = 1; osc_en = 1; step(4);
    lock_in = 0; step(3); lock_in = 1; step(QC / 2);
    lock_in = 0; step(1); lock_in = 1; step(QC + 6);

    phase = "R8 full stop"; full_stop = 1; step(4);
    full_stop = 0; step(QC + 4);
    phase = "R7 filter restart after osc toggle"; osc_en = 0; step(1);
    osc_en = 1; step(QC + 4);

    phase = "R10 masks"; lock_ie = 0; step(3); osc_ie = 0; step(3);
    lock_ie = 1; step(3); osc_ie = 1; wr(2'b01); step(3); wr(2'b10); step(3);

    phase = "R1 reset reapplied"; rst = 1; step(3); rst = 0; step(2);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule